// File: doc/BRIEF.md
# Registered Shift and Rotate Unit with Flag Outputs

This block shifts or rotates a data word by an amount given in a second operand. A four-bit mode word selects the operation. It sets the direction, chooses zero or sign fill for right shifts, and picks a plain shift or a rotation. It can also chain the incoming carry flag onto the top of the word, so that the operation works on a word one bit wider than the data.

The result, a new carry and a new overflow are registered once, at the clock edge after the operands are presented. The block does not decode instructions and does not hold the flag register. The caller keeps the flags and passes the current carry back in on the next operation.

Top module: `srot_unit`

## Requirements
- R1: While `rst_n` is low, `result_q`, `carry_q` and `ovf_q` are cleared to zero at each clock edge.
- R2: The outputs present, one clock edge after sampling, the values computed from the operands sampled at that edge.
- R3: Mode encoding: bit 3 = 1 selects left, bit 2 chains the carry, bit 1 selects rotate, bit 0 selects arithmetic fill. A plain left shift (mode 1000 or 1001) fills with zeros, so the arithmetic bit has no effect on it.
- R4: A plain right shift (mode 0000) fills with zeros. Mode 0001 fills with copies of the original bit 15.
- R5: A plain rotate (bit 2 = 0, bit 1 = 1) rotates the 16-bit word, and bit 0 has no effect.
- R6: With the carry chained, the operation works on the 17-bit word {carry_in, data}. Rotates wrap through all 17 bits. An arithmetic right shift fills with copies of carry_in. The new carry is bit 16 of the shifted word.
- R7: Without the chained carry, the new carry is the last bit moved out of the word: data[16-n] for a left shift or rotate, and data[n-1] for a right one. An amount of 0 returns the data unchanged and passes carry_in through.
- R8: Overflow is set only for left operations, when bit 15 holds a value different from the original bit 15 after any single-bit step. Right operations always clear it.
- R9: Only bits 3:0 of `opnd_b` form the amount n (0 to 15). Bits 15:4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 16 | Data word to shift |
| opnd_b | input | 16 | Amount operand; the low four bits are used |
| mode | input | 4 | Operation select: left, chain, rotate, arithmetic |
| carry_in | input | 1 | Current carry flag |
| result_q | output | 16 | Registered shifted word |
| carry_q | output | 1 | Registered new carry |
| ovf_q | output | 1 | Registered new overflow |

## Verification
In a single left operation, the new carry and the overflow are both produced in the same cycle. In chained modes, the incoming carry also serves as the fill or wrap source and as the origin of the outgoing flag. The bench provokes these cases by sweeping all sixteen modes against amounts 0, 1, 8 and 15. It uses alternating-sign and single-bit data, with both carry values, and then adds random vectors whose upper amount bits are set. A step-by-step model applies n single-bit moves and records every sign change. It judges the result, the carry and the overflow separately on every clock.

// File: rtl/srot_pkg.sv
package srot_pkg;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic left;
        logic chain;
        logic rot;
        logic arith;
    } mode_t;
endpackage

// File: rtl/srot_datapath.sv
module srot_datapath
    import srot_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [AW-1:0] amt,
    input  mode_t         mode,
    input  logic          cin,
    output logic [W:0]    word
);
    localparam int IW = $clog2(W + 1);

    logic [W:0] ext;
    logic       fill_bit;
    int         len;

    assign ext = {cin, data};

    always_comb begin
        len      = mode.chain ? W + 1 : W;
        fill_bit = mode.arith & (mode.chain ? cin : data[W-1]);
        word     = '0;
        for (int i = 0; i <= W; i++) begin
            int src;
            logic bit_v;
            if (mode.left) begin
                src = i - int'(amt);
                if (src < 0) begin
                    bit_v = mode.rot ? ext[IW'(src + len)] : 1'b0;
                end else begin
                    bit_v = ext[IW'(src)];
                end
            end else begin
                src = i + int'(amt);
                if (src >= len) begin
                    bit_v = mode.rot ? ext[IW'(src - len)] : fill_bit;
                end else begin
                    bit_v = ext[IW'(src)];
                end
            end
            if (i < len) begin
                word[i] = bit_v;
            end
        end
    end
endmodule

// File: rtl/srot_flags.sv
module srot_flags
    import srot_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [AW-1:0] amt,
    input  mode_t         mode,
    input  logic          cin,
    input  logic [W:0]    word,
    output logic          cy,
    output logic          ov
);
    localparam int IW = $clog2(W + 1);

    logic [W-1:1] sign_flip;

    for (genvar k = 1; k < W; k++) begin : g_step
        assign sign_flip[k] = (int'(amt) >= k) && (data[W-1-k] != data[W-1]);
    end

    always_comb begin
        if (mode.chain) begin
            cy = word[W];
        end else if (amt == '0) begin
            cy = cin;
        end else if (mode.left) begin
            cy = data[IW'(W - int'(amt))];
        end else begin
            cy = data[IW'(int'(amt) - 1)];
        end
        ov = mode.left & (|sign_flip);
    end
endmodule

// File: rtl/srot_unit.sv
module srot_unit
    import srot_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [3:0]   mode,
    input  logic         carry_in,
    output logic [W-1:0] result_q,
    output logic         carry_q,
    output logic         ovf_q
);
    localparam int AW = $clog2(W);

    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
        logic         ov;
    } state_t;

    state_t        st_d, st_q;
    mode_t         mode_s;
    logic [AW-1:0] amt;
    logic [W:0]    word;
    logic          cy_n, ov_n;
    logic          unused_amt_hi;

    assign mode_s        = mode_t'(mode);
    assign amt           = opnd_b[AW-1:0];
    assign unused_amt_hi = ^opnd_b[W-1:AW];

    srot_datapath #(.W(W), .AW(AW)) u_path (
        .data (opnd_a),
        .amt  (amt),
        .mode (mode_s),
        .cin  (carry_in),
        .word (word)
    );

    srot_flags #(.W(W), .AW(AW)) u_flags (
        .data (opnd_a),
        .amt  (amt),
        .mode (mode_s),
        .cin  (carry_in),
        .word (word),
        .cy   (cy_n),
        .ov   (ov_n)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = word[W-1:0];
        st_d.cy  = cy_n;
        st_d.ov  = ov_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_q = st_q.res;
    assign carry_q  = st_q.cy;
    assign ovf_q    = st_q.ov;
endmodule

// File: rtl/srot_unit_chk.sv
module srot_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [3:0]   mode,
    input logic         carry_in,
    input logic [W-1:0] result_q,
    input logic         carry_q,
    input logic         ovf_q
);
    localparam int AW = $clog2(W);

    logic primed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // R8
    right_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(mode[3])) |-> !ovf_q);

    // R7
    zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(opnd_b[AW-1:0]) == '0) |->
            (result_q == $past(opnd_a) && carry_q == $past(carry_in)));

    // R5
    plain_rot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(mode[2:1]) == 2'b01) |->
            ($countones(result_q) == $countones($past(opnd_a))));

    // R6
    chain_rot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(mode[2:1]) == 2'b11) |->
            ($countones({carry_q, result_q}) == $countones({$past(carry_in), $past(opnd_a)})));

    // R3
    left_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(mode[3:1]) == 3'b100 && $past(opnd_b[AW-1:0]) != '0) |->
            !result_q[0]);
endmodule

bind srot_unit srot_unit_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .mode     (mode),
    .carry_in (carry_in),
    .result_q (result_q),
    .carry_q  (carry_q),
    .ovf_q    (ovf_q)
);

// File: tb/srot_unit_test.sv
module srot_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [3:0]  mode = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result_q;
    logic        carry_q, ovf_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    srot_unit uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .mode(mode), .carry_in(carry_in),
        .result_q(result_q), .carry_q(carry_q), .ovf_q(ovf_q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Step-by-step model: n single-bit moves, sign watched after each.
    task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [3:0] m,
                         input logic c, output logic [15:0] r, output logic cy, output logic ov);
        int n;
        logic [16:0] w;
        logic sign0;
        n = int'(b[3:0]);
        w = {c, a};
        cy = c;
        ov = 1'b0;
        sign0 = a[15];
        for (int s = 0; s < n; s++) begin
            if (m[2]) begin
                if (m[3]) w = {w[15:0], m[1] ? w[16] : 1'b0};
                else      w = {m[1] ? w[0] : (m[0] & w[16]), w[16:1]};
                cy = w[16];
            end else begin
                if (m[3]) begin
                    cy = w[15];
                    w[15:0] = {w[14:0], m[1] ? w[15] : 1'b0};
                end else begin
                    cy = w[0];
                    w[15:0] = {m[1] ? w[0] : (m[0] & w[15]), w[15:1]};
                end
            end
            if (m[3] && w[15] != sign0) ov = 1'b1;
        end
        r = w[15:0];
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [3:0] m,
                         input logic c, input string extra);
        logic [15:0] er;
        logic ec, eo;
        string rtag;
        opnd_a = a; opnd_b = b; mode = m; carry_in = c;
        model(a, b, m, c, er, ec, eo);
        if (m[2])                rtag = "R6";
        else if (m[1])           rtag = "R5";
        else if (m[3])           rtag = "R3";
        else                     rtag = "R4";
        @(negedge clk);
        check({"R2/", rtag, extra, " result"}, int'(result_q), int'(er));
        check({m[2] ? "R6" : "R7", extra, " carry"}, int'(carry_q), int'(ec));
        check({"R8", extra, " overflow"}, int'(ovf_q), int'(eo));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [5];
        int amts [4];
        pats[0] = 16'h8000; pats[1] = 16'h5555; pats[2] = 16'hC001;
        pats[3] = 16'h0001; pats[4] = 16'h7F0E;
        amts[0] = 0; amts[1] = 1; amts[2] = 8; amts[3] = 15;

        // R1: reset clears outputs even with live operands
        opnd_a = 16'hFFFF; opnd_b = 16'h0003; mode = 4'b1010; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 result", int'(result_q), 0);
        check("R1 carry", int'(carry_q), 0);
        check("R1 overflow", int'(ovf_q), 0);
        rst_n = 1'b1;

        // Mode sweep over corner amounts and patterns, both carry values
        for (int m = 0; m < 16; m++)
            for (int p = 0; p < 5; p++)
                for (int k = 0; k < 4; k++)
                    for (int c = 0; c < 2; c++)
                        apply(pats[p], 16'(amts[k]), 4'(m), 1'(c), "");

        // R9: upper amount bits set must not matter
        for (int i = 0; i < 64; i++)
            apply(16'($urandom), {12'($urandom) | 12'h800, 4'(i)}, 4'(i >> 2), 1'(i), " R9");

        // Random mix
        for (int i = 0; i < 400; i++)
            apply(16'($urandom), 16'($urandom), 4'($urandom), 1'($urandom), "");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule